// File: doc/BRIEF.md
# Crosspoint Programming Write Sequencer

This block sits on the host side of an analog crosspoint switch matrix and drives the matrix's parallel control-memory port. A host presents one command at a time on a valid/ready handshake. A command either sets one crosspoint, chosen by a logical row (0 to 15) and a column (0 to 7), to on or off, or clears the whole matrix.

For a write, the block raises chip select and drives address and data. It then pulses the strobe and keeps everything stable through a hold window. For a clear, it drives a master reset pulse. Every window is a whole number of clock cycles, rounded up from a nanosecond rule at the configured clock period. An optional settle window then lets the analog switch state settle before the next command is taken.

The matrix's row address lines are not in ascending order. The block therefore turns the logical row number into the row code that the matrix decodes. All control outputs come straight from registers.

Top module: `xpt_wr_seq`

## Requirements
- R1: In the cycle after synchronous reset, cmd_ready is 1 and xp_cs, xp_strobe and xp_reset are 0.
- R2: A command is accepted on a rising edge where cmd_valid and cmd_ready are both 1. From that edge on, cmd_ready is 0 until the command completes, and cmd_valid is ignored while cmd_ready is 0.
- R3: For a write, xp_cs, xp_addr and xp_data become valid on the accepting edge. xp_strobe rises SETUP_CYC cycles later, where SETUP_CYC = ceil(SETUP_NS*1000/CLK_PS), with a minimum of 1.
- R4: xp_strobe stays high for exactly STRB_CYC = ceil(STRB_NS*1000/CLK_PS) cycles.
- R5: After xp_strobe falls, xp_cs, xp_addr and xp_data hold for HOLD_CYC = ceil(HOLD_NS*1000/CLK_PS) cycles, and then xp_cs falls. xp_addr and xp_data do not change while xp_cs is high.
- R6: xp_addr[6:4] carries the column number and xp_addr[3:0] carries the row code. xp_data equals cmd_on (1 = switch on).
- R7: Row codes: logical rows 0 to 5 give codes 0 to 5, rows 6 to 11 give 8 to 13, rows 12 and 13 give 6 and 7, and rows 14 and 15 give 14 and 15.
- R8: A clear command (cmd_clear = 1) drives xp_reset high for RST_CYC = ceil(RST_NS*1000/CLK_PS) cycles, starting on the accepting edge. xp_cs and xp_strobe stay low throughout, and xp_reset is never high while xp_cs is high.
- R9: With SETTLE_EN = 1, cmd_ready returns SETTLE_CYC = ceil(SETTLE_NS*1000/CLK_PS) cycles after xp_cs falls (write) or xp_reset falls (clear). With SETTLE_EN = 0, it returns on the same edge.
- R10: While cmd_ready is 1, xp_cs, xp_strobe and xp_reset are all 0, and xp_strobe is never high without xp_cs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_clear | input | 1 | 1 = clear all crosspoints, 0 = single write |
| cmd_row | input | ROW_W | Logical row number |
| cmd_col | input | COL_W | Column number |
| cmd_on | input | 1 | Switch state to write (1 = on) |
| xp_cs | output | 1 | Chip select to the matrix |
| xp_addr | output | ROW_W+COL_W | {column, row code} |
| xp_data | output | 1 | Data bit to the matrix |
| xp_strobe | output | 1 | Write strobe, active high |
| xp_reset | output | 1 | Master clear, active high |

## Verification
Writes are issued to every logical row at least once, with varied columns and both data values. A wrong row code or a swapped address field then shows up on the captured address bus. Each write and each clear is recorded cycle by cycle from the accepting edge. This separates a short or long setup, strobe, hold, reset or settle window from the correct one, to the exact cycle. A second command held valid during a busy period checks that the block neither restarts nor changes the address mid-write.

// File: rtl/xpt_wr_pkg.sv
package xpt_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_STRB   = 3'd2,
    ST_HOLD   = 3'd3,
    ST_CLR    = 3'd4,
    ST_SETTLE = 3'd5
  } seq_state_t;

  // Round a nanosecond rule up to whole clock cycles, never below one.
  function automatic int ns_to_cyc(input int ns, input int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/xpt_row_map.sv
module xpt_row_map #(
  parameter int ROW_W = 4
) (
  input  logic [ROW_W-1:0] row_in,
  output logic [ROW_W-1:0] code_out
);
  // Logical rows 6..11 sit two codes higher; rows 12/13 fill codes 6/7.
  always_comb begin
    if (row_in < ROW_W'(6))
      code_out = row_in;
    else if (row_in < ROW_W'(12))
      code_out = row_in + ROW_W'(2);
    else if (row_in < ROW_W'(14))
      code_out = row_in - ROW_W'(6);
    else
      code_out = row_in;
  end
endmodule

// File: rtl/xpt_phase_timer.sv
module xpt_phase_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - CNT_W'(1);
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/xpt_wr_seq.sv
module xpt_wr_seq
  import xpt_wr_pkg::*;
#(
  parameter int ROW_W     = 4,
  parameter int COL_W     = 3,
  parameter int CLK_PS    = 5000,
  parameter int SETUP_NS  = 10,
  parameter int STRB_NS   = 20,
  parameter int HOLD_NS   = 10,
  parameter int RST_NS    = 40,
  parameter int SETTLE_NS = 100,
  parameter bit SETTLE_EN = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic                   cmd_clear,
  input  logic [ROW_W-1:0]       cmd_row,
  input  logic [COL_W-1:0]       cmd_col,
  input  logic                   cmd_on,
  output logic                   xp_cs,
  output logic [ROW_W+COL_W-1:0] xp_addr,
  output logic                   xp_data,
  output logic                   xp_strobe,
  output logic                   xp_reset
);
  localparam int SETUP_CYC  = ns_to_cyc(SETUP_NS, CLK_PS);
  localparam int STRB_CYC   = ns_to_cyc(STRB_NS, CLK_PS);
  localparam int HOLD_CYC   = ns_to_cyc(HOLD_NS, CLK_PS);
  localparam int RST_CYC    = ns_to_cyc(RST_NS, CLK_PS);
  localparam int SETTLE_CYC = ns_to_cyc(SETTLE_NS, CLK_PS);
  localparam int MAX_A      = (SETUP_CYC > STRB_CYC) ? SETUP_CYC : STRB_CYC;
  localparam int MAX_B      = (HOLD_CYC > RST_CYC) ? HOLD_CYC : RST_CYC;
  localparam int MAX_C      = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CYC    = (MAX_C > SETTLE_CYC) ? MAX_C : SETTLE_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  seq_state_t       state, state_nx;
  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  logic [ROW_W-1:0] row_code;

  xpt_row_map #(.ROW_W(ROW_W)) u_map (
    .row_in  (cmd_row),
    .code_out(row_code)
  );

  xpt_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .done    (tmr_done)
  );

  // Next-state and timer reload
  always_comb begin
    state_nx = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state)
      ST_IDLE: if (cmd_valid && cmd_ready) begin
        tmr_load = 1'b1;
        if (cmd_clear) begin
          state_nx = ST_CLR;
          tmr_val  = CNT_W'(RST_CYC - 1);
        end else begin
          state_nx = ST_SETUP;
          tmr_val  = CNT_W'(SETUP_CYC - 1);
        end
      end
      ST_SETUP: if (tmr_done) begin
        state_nx = ST_STRB;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(STRB_CYC - 1);
      end
      ST_STRB: if (tmr_done) begin
        state_nx = ST_HOLD;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(HOLD_CYC - 1);
      end
      ST_HOLD, ST_CLR: if (tmr_done) begin
        if (SETTLE_EN) begin
          state_nx = ST_SETTLE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(SETTLE_CYC - 1);
        end else begin
          state_nx = ST_IDLE;
        end
      end
      ST_SETTLE: if (tmr_done) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cmd_ready <= 1'b1;
      xp_cs     <= 1'b0;
      xp_strobe <= 1'b0;
      xp_reset  <= 1'b0;
      xp_addr   <= '0;
      xp_data   <= 1'b0;
    end else begin
      state <= state_nx;
      case (state)
        ST_IDLE: if (cmd_valid && cmd_ready) begin
          cmd_ready <= 1'b0;
          if (cmd_clear) begin
            xp_reset <= 1'b1;
          end else begin
            xp_cs   <= 1'b1;
            xp_addr <= {cmd_col, row_code};
            xp_data <= cmd_on;
          end
        end
        ST_SETUP: if (tmr_done) xp_strobe <= 1'b1;
        ST_STRB:  if (tmr_done) xp_strobe <= 1'b0;
        ST_HOLD: if (tmr_done) begin
          xp_cs <= 1'b0;
          if (!SETTLE_EN) cmd_ready <= 1'b1;
        end
        ST_CLR: if (tmr_done) begin
          xp_reset <= 1'b0;
          if (!SETTLE_EN) cmd_ready <= 1'b1;
        end
        ST_SETTLE: if (tmr_done) cmd_ready <= 1'b1;
        default: ;
      endcase
    end
  end

  AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    xp_strobe |-> xp_cs); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (!xp_cs && !xp_strobe && !xp_reset)); // R10
  AST_NO_RESET_WITH_CS: assert property (@(posedge clk) disable iff (rst)
    xp_reset |-> !xp_cs); // R8
  AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (xp_cs && $past(xp_cs)) |-> ($stable(xp_addr) && $stable(xp_data))); // R5
  AST_CS_BEFORE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(xp_strobe) |-> $past(xp_cs)); // R3
  AST_CS_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    $fell(xp_strobe) |-> xp_cs); // R5
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready); // R2
endmodule

// File: tb/xpt_wr_seq_test.sv
module xpt_wr_seq_test;
  localparam int CLK_PS  = 5000;
  localparam int NSAMP   = 40;
  localparam int T_SETUP = (10 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int T_STRB  = (20 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int T_HOLD  = (10 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int T_RST   = (40 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int T_SETL  = (100 * 1000 + CLK_PS - 1) / CLK_PS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_clear = 1'b0, cmd_on = 1'b0;
  logic [3:0] cmd_row = '0;
  logic [2:0] cmd_col = '0;
  logic cmd_ready, xp_cs, xp_data, xp_strobe, xp_reset;
  logic [6:0] xp_addr;

  int errors = 0;
  int checks = 0;

  logic       s_cs [NSAMP], s_stb [NSAMP], s_rst [NSAMP], s_rdy [NSAMP], s_dat [NSAMP];
  logic [6:0] s_addr [NSAMP];

  always #2.5 clk = ~clk;

  xpt_wr_seq #(.CLK_PS(CLK_PS)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_clear(cmd_clear), .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_on(cmd_on),
    .xp_cs(xp_cs), .xp_addr(xp_addr), .xp_data(xp_data),
    .xp_strobe(xp_strobe), .xp_reset(xp_reset)
  );

  function automatic logic [3:0] exp_code(input int r);
    if (r < 6) return 4'(r);
    else if (r < 12) return 4'(r + 2);
    else if (r < 14) return 4'(r - 6);
    else return 4'(r);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Offer a command, wait for the accepting edge, then record NSAMP cycles.
  // poke=1 offers a second command during the busy period (row 9).
  task automatic issue(input bit clr, input int row, input int col, input bit on, input bit poke);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_clear = clr;
    cmd_row = 4'(row); cmd_col = 3'(col); cmd_on = on;
    @(posedge clk);
    for (int k = 0; k < NSAMP; k++) begin
      @(negedge clk);
      cmd_valid = (poke && k >= 10 && k < 15);
      if (poke) begin cmd_row = 4'd9; cmd_on = ~on; cmd_clear = 1'b0; end
      s_cs[k] = xp_cs; s_stb[k] = xp_strobe; s_rst[k] = xp_reset;
      s_rdy[k] = cmd_ready; s_dat[k] = xp_data; s_addr[k] = xp_addr;
    end
    cmd_valid = 1'b0;
  endtask

  task automatic check_write(input int row, input int col, input bit on, input bit poke);
    int first_stb, n_stb, n_cs, first_rdy, bad_addr, bad_dat, n_rst, busy_rdy;
    issue(1'b0, row, col, on, poke);
    first_stb = -1; n_stb = 0; n_cs = 0; first_rdy = -1;
    bad_addr = 0; bad_dat = 0; n_rst = 0; busy_rdy = 0;
    for (int k = 0; k < NSAMP; k++) begin
      if (s_stb[k]) begin n_stb++; if (first_stb < 0) first_stb = k; end
      if (s_cs[k]) begin
        n_cs++;
        if (s_addr[k] != {3'(col), exp_code(row)}) bad_addr++;
        if (s_dat[k] != on) bad_dat++;
      end
      if (s_rst[k]) n_rst++;
      if (s_rdy[k] && first_rdy < 0) first_rdy = k;
      if (k < T_SETUP + T_STRB + T_HOLD + T_SETL && s_rdy[k]) busy_rdy++;
    end
    check("R3 strobe rises after setup window", first_stb, T_SETUP);
    check("R4 strobe width", n_stb, T_STRB);
    check("R5 cs length incl hold", n_cs, T_SETUP + T_STRB + T_HOLD);
    check("R5 cs still high at first hold cycle", int'(s_cs[T_SETUP + T_STRB]), 1);
    check("R6/R7 address mismatches while cs high", bad_addr, 0);
    check("R6 data mismatches while cs high", bad_dat, 0);
    check("R8 no reset during write", n_rst, 0);
    check("R2 ready low while busy", busy_rdy, 0);
    check("R9 ready returns after settle", first_rdy, T_SETUP + T_STRB + T_HOLD + T_SETL);
    check("R10 cs low once ready", int'(s_cs[NSAMP-1]), 0);
  endtask

  task automatic test_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 ready after reset", int'(cmd_ready), 1);
    check("R1 cs after reset", int'(xp_cs), 0);
    check("R1 strobe after reset", int'(xp_strobe), 0);
    check("R1 reset output after reset", int'(xp_reset), 0);
  endtask

  task automatic test_rows;
    for (int r = 0; r < 16; r++) begin
      issue(1'b0, r, (r * 3) % 8, r[0], 1'b0);
      check("R7 row code", int'(s_addr[1][3:0]), int'(exp_code(r)));
      check("R6 column field", int'(s_addr[1][6:4]), (r * 3) % 8);
    end
  endtask

  task automatic test_clear;
    int n_rst, n_cs, n_stb, first_rdy;
    issue(1'b1, 3, 2, 1'b1, 1'b0);
    n_rst = 0; n_cs = 0; n_stb = 0; first_rdy = -1;
    for (int k = 0; k < NSAMP; k++) begin
      if (s_rst[k]) n_rst++;
      if (s_cs[k]) n_cs++;
      if (s_stb[k]) n_stb++;
      if (s_rdy[k] && first_rdy < 0) first_rdy = k;
    end
    check("R8 reset pulse starts on accept", int'(s_rst[0]), 1);
    check("R8 reset pulse width", n_rst, T_RST);
    check("R8 cs low during clear", n_cs, 0);
    check("R8 strobe low during clear", n_stb, 0);
    check("R9 ready after clear settle", first_rdy, T_RST + T_SETL);
  endtask

  task automatic test_busy_ignored;
    int late_cs;
    check_write(13, 5, 1'b1, 1'b1);
    late_cs = 0;
    for (int k = T_SETUP + T_STRB + T_HOLD; k < NSAMP; k++)
      if (s_cs[k] || s_stb[k]) late_cs++;
    check("R2 command offered while busy not started", late_cs, 0);
    check("R2 address unchanged by busy command", int'(s_addr[T_SETUP + T_STRB][3:0]), int'(exp_code(13)));
  endtask

  initial begin
    test_reset();
    check_write(0, 0, 1'b1, 1'b0);
    check_write(7, 6, 1'b0, 1'b0);
    check_write(12, 7, 1'b1, 1'b0);
    test_rows();
    test_clear();
    test_busy_ignored();
    check_write(15, 1, 1'b0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule